// File: doc/BRIEF.md
# Serial Two's Complementer

This block negates a WIDTH-bit word in place, one bit per clock, starting with the least significant bit. The caller writes an operand through a parallel load port while the block is idle and then pulses a start input. On each busy cycle the lowest bit leaves the operand register. It is combined with a one-bit history state, and the resulting bit enters the register at the opposite end. After WIDTH such rotations the register holds the two's complement of the operand, and a one-cycle done pulse reports the end. No adder is used.

The history state can take one of two forms, chosen by a parameter. The default form is a sticky flag. The flag is clear at the start of a word and is set by the first 1 that passes. While it is clear, bits pass unchanged. Once it is set, every later bit is inverted. The alternative form is a serial incrementer. Its carry flop is preset to 1 at the start of a word, each inverted operand bit is added to the carry, and the new carry is the AND of the two. Both forms give the same word. A serial tap can be enabled to show each result bit, with a valid strobe, in the cycle where that bit is produced.

Top module: `serial_negator`

## Requirements
- R1: A load pulse in idle writes the load value into the result port on the next clock. A load pulse while busy is ignored, so it does not change the final result.
- R2: A start pulse sampled in idle raises busy on the next clock. Busy stays high for exactly WIDTH cycles. Done is then high for exactly one cycle, in the cycle after busy falls.
- R3: When done is high, the result port holds (2^WIDTH - operand) mod 2^WIDTH.
- R4: While busy, the serial valid strobe is high and the serial bit carries the result bits in order, with bit 0 in the first busy cycle. When idle, the valid strobe is low.
- R5: Every bit up to and including the lowest 1 of the operand leaves the block unchanged. Every higher bit leaves inverted.
- R6: The history state is reset at each start, so a word never depends on the word before it. An all-zero word that follows a word containing ones still gives all zeros.
- R7: An all-zero operand gives all zeros. The operand 1 followed by zeros gives itself.
- R8: A start pulse while busy is ignored. Busy length and result are unchanged.
- R9: A synchronous active-high reset clears the result, busy, done and the serial strobe.
- R10: The incrementer form (INCR_MODE=1) gives the same serial bits, result and timing as the flag form for every operand.
- R11: When WIDTH is 6, the operand 001010 gives 110110.
- R12: When load and start arrive in the same idle cycle, the new value is loaded and then negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Write load_val_i into the operand register (only taken in idle) |
| load_val_i | input | WIDTH | Operand to negate |
| start_i | input | 1 | Begin a negation (only taken in idle) |
| busy_o | output | 1 | High during the WIDTH rotation cycles |
| done_o | output | 1 | One-cycle pulse after the last rotation |
| result_o | output | WIDTH | Register contents. This is the negated word once done has pulsed. |
| ser_bit_o | output | 1 | Result bit produced in this cycle |
| ser_vld_o | output | 1 | Qualifies ser_bit_o |

## Verification
The assertions take for granted that start and load are plain synchronous pulses and that reset is the only way to abandon a word in progress. They also assume that the history state only changes when a word starts or a bit is rotated. The stimulus drives every input at the falling clock edge. It holds load and start for one cycle each, and it sends start or load during a busy window only on purpose, to test that they are ignored. Reset is raised once in the middle of a word, and every later word begins with a fresh start pulse.

// File: rtl/serneg_pkg.sv
package serneg_pkg;

   typedef enum logic {
      SN_IDLE = 1'b0,
      SN_RUN  = 1'b1
   } sn_state_e;

   // form of the one-bit history kept across a word
   typedef enum logic {
      SN_HIST_FLAG  = 1'b0,
      SN_HIST_CARRY = 1'b1
   } sn_hist_e;

endpackage

// File: rtl/serneg_bitcnt.sv
module serneg_bitcnt #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_i,
   input  logic en_i,
   output logic last_o
);
   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == LAST);

   p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST)
      else $error("bit counter out of range");

endmodule

// File: rtl/serneg_ctrl.sv
module serneg_ctrl
   import serneg_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   output logic busy_o,
   output logic done_o,
   output logic clr_o,
   output logic shift_o
);
   sn_state_e state_q;
   logic      done_q;
   logic      last;
   logic      accept;

   assign accept  = (state_q == SN_IDLE) && start_i;
   assign shift_o = (state_q == SN_RUN);
   assign clr_o   = accept;

   serneg_bitcnt #(.WIDTH(WIDTH)) i_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr_i (accept),
      .en_i  (shift_o),
      .last_o(last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SN_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SN_IDLE: if (start_i) state_q <= SN_RUN;
            SN_RUN: begin
               if (last) begin
                  state_q <= SN_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= SN_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q == SN_RUN);
   assign done_o = done_q;

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q)
      else $error("done longer than one cycle");

   p_done_after_run_r2: assert property (@(posedge clk) disable iff (rst)
      (busy_o && last) |=> (done_q && !busy_o))
      else $error("done missing after last rotation");

   p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
      (busy_o && !last && start_i) |=> busy_o)
      else $error("start while busy cut the run short");

   p_reset_clears_r9: assert property (@(posedge clk)
      rst |=> (!busy_o && !done_q))
      else $error("reset left busy or done set");

endmodule

// File: rtl/serneg_bitcell.sv
module serneg_bitcell
   import serneg_pkg::*;
#(
   parameter sn_hist_e HIST = SN_HIST_FLAG
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_i,
   input  logic en_i,
   input  logic bit_i,
   output logic bit_o
);
   generate
      if (HIST == SN_HIST_FLAG) begin : g_flag
         logic seen_q;

         always_ff @(posedge clk) begin
            if (rst || clr_i)  seen_q <= 1'b0;
            else if (en_i)     seen_q <= seen_q | bit_i;
         end

         assign bit_o = bit_i ^ seen_q;

         p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            (seen_q && !clr_i) |=> seen_q)
            else $error("history flag dropped within a word");

         p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
            clr_i |=> !seen_q)
            else $error("history flag not cleared at start");
      end else begin : g_carry
         logic carry_q;
         logic inv;

         assign inv = ~bit_i;

         always_ff @(posedge clk) begin
            if (rst)          carry_q <= 1'b0;
            else if (clr_i)   carry_q <= 1'b1;
            else if (en_i)    carry_q <= inv & carry_q;
         end

         assign bit_o = inv ^ carry_q;

         p_carry_monotone_r10: assert property (@(posedge clk) disable iff (rst)
            (!carry_q && !clr_i) |=> !carry_q)
            else $error("carry rose within a word");

         p_carry_preset_r6: assert property (@(posedge clk) disable iff (rst)
            clr_i |=> carry_q)
            else $error("carry not preset at start");
      end
   endgenerate

endmodule

// File: rtl/serneg_shreg.sv
module serneg_shreg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic             lsb_o,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q_q;

   always_ff @(posedge clk) begin
      if (rst)          q_q <= '0;
      else if (shift_i) q_q <= {bit_i, q_q[WIDTH-1:1]};
      else if (load_i)  q_q <= load_val_i;
   end

   assign lsb_o = q_q[0];
   assign q_o   = q_q;

   p_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (!shift_i && !load_i) |=> $stable(q_q))
      else $error("operand register changed without load or shift");

   p_load_r1: assert property (@(posedge clk) disable iff (rst)
      (load_i && !shift_i) |=> (q_q == $past(load_val_i)))
      else $error("load value not captured");

endmodule

// File: rtl/serial_negator.sv
module serial_negator
   import serneg_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit INCR_MODE  = 1'b0,
   parameter bit SERIAL_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             start_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] result_o,
   output logic             ser_bit_o,
   output logic             ser_vld_o
);
   localparam sn_hist_e HIST = INCR_MODE ? SN_HIST_CARRY : SN_HIST_FLAG;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("serial_negator: WIDTH must be at least 2");
      end
   endgenerate

   logic clr;
   logic shift;
   logic lsb;
   logic out_bit;
   logic load_ok;

   serneg_ctrl #(.WIDTH(WIDTH)) i_ctrl (
      .clk    (clk),
      .rst    (rst),
      .start_i(start_i),
      .busy_o (busy_o),
      .done_o (done_o),
      .clr_o  (clr),
      .shift_o(shift)
   );

   assign load_ok = load_i & ~shift;

   serneg_shreg #(.WIDTH(WIDTH)) i_shreg (
      .clk       (clk),
      .rst       (rst),
      .load_i    (load_ok),
      .load_val_i(load_val_i),
      .shift_i   (shift),
      .bit_i     (out_bit),
      .lsb_o     (lsb),
      .q_o       (result_o)
   );

   serneg_bitcell #(.HIST(HIST)) i_cell (
      .clk  (clk),
      .rst  (rst),
      .clr_i(clr),
      .en_i (shift),
      .bit_i(lsb),
      .bit_o(out_bit)
   );

   generate
      if (SERIAL_OUT) begin : g_tap
         assign ser_bit_o = shift & out_bit;
         assign ser_vld_o = shift;
      end else begin : g_no_tap
         assign ser_bit_o = 1'b0;
         assign ser_vld_o = 1'b0;
      end
   endgenerate

   p_busy_load_r1: assert property (@(posedge clk) disable iff (rst)
      (busy_o && load_i) |=> (result_o[WIDTH-1] == $past(out_bit)))
      else $error("load during busy disturbed the rotation");

endmodule

// File: tb/test_serial_negator.sv
`timescale 1ns/1ps
module test_serial_negator;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load = 1'b0;
   logic       start = 1'b0;
   logic [7:0] lval = '0;

   logic       m_busy, m_done, m_sbit, m_svld;
   logic [7:0] m_res;
   logic       c_busy, c_done, c_sbit, c_svld;
   logic [7:0] c_res;
   logic       w_busy, w_done, w_sbit, w_svld;
   logic [5:0] w_res;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   serial_negator #(.WIDTH(8), .INCR_MODE(1'b0)) i_serial_negator (
      .clk(clk), .rst(rst), .load_i(load), .load_val_i(lval), .start_i(start),
      .busy_o(m_busy), .done_o(m_done), .result_o(m_res),
      .ser_bit_o(m_sbit), .ser_vld_o(m_svld));

   serial_negator #(.WIDTH(8), .INCR_MODE(1'b1)) i_serial_negator_inc (
      .clk(clk), .rst(rst), .load_i(load), .load_val_i(lval), .start_i(start),
      .busy_o(c_busy), .done_o(c_done), .result_o(c_res),
      .ser_bit_o(c_sbit), .ser_vld_o(c_svld));

   serial_negator #(.WIDTH(6)) i_serial_negator_w6 (
      .clk(clk), .rst(rst), .load_i(load), .load_val_i(lval[5:0]), .start_i(start),
      .busy_o(w_busy), .done_o(w_done), .result_o(w_res),
      .ser_bit_o(w_sbit), .ser_vld_o(w_svld));

   // operand in [15:8], expected negation in [7:0]
   localparam logic [15:0] VEC [12] = '{
      16'h0A_F6, 16'h01_FF, 16'h00_00, 16'h80_80, 16'hFF_01, 16'h7F_81,
      16'h55_AB, 16'h3C_C4, 16'hFE_02, 16'h40_C0, 16'h5B_A5, 16'h00_00
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_word(input logic [7:0] v, input logic [7:0] e,
                           input bit poke_start, input bit poke_load);
      @(negedge clk); load = 1'b1; lval = v;
      @(negedge clk); load = 1'b0; start = 1'b1;
      chk(m_res == v, "R1 load in idle", m_res, v);
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 8; i++) begin
         chk(m_busy && c_busy, "R2 busy window", {m_busy, c_busy}, 2'b11);
         chk(m_svld && m_sbit == e[i], "R4 R5 serial bit", {m_svld, m_sbit}, {1'b1, e[i]});
         chk(c_svld && c_sbit == e[i], "R10 incrementer serial bit", {c_svld, c_sbit}, {1'b1, e[i]});
         if (i == 3 && poke_start) start = 1'b1;
         if (i == 3 && poke_load) begin load = 1'b1; lval = ~v; end
         @(negedge clk); start = 1'b0; load = 1'b0;
      end
      chk(!m_busy && m_done, "R2 done after WIDTH cycles", {m_busy, m_done}, 2'b01);
      chk(m_res == e, "R3 result", m_res, e);
      chk(c_done && c_res == e, "R10 incrementer result", c_res, e);
      @(negedge clk);
      chk(!m_done && !m_svld && !c_done, "R2 R4 done single, strobe low", {m_done, m_svld}, 2'b00);
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9 reset state
      chk(m_res == 8'h00 && !m_busy && !m_done && !m_svld, "R9 reset state",
          {m_res, m_busy, m_done, m_svld}, 11'h0);

      // table walk; covers R3 R4 R5 R7 R10, and R6 via 01 -> 00 and 5B -> 00
      for (int k = 0; k < 12; k++) begin
         run_word(VEC[k][15:8], VEC[k][7:0], 1'b0, 1'b0);
         if (k == 0) chk(w_res == 6'b110110, "R11 six-bit 001010", w_res, 6'b110110);
      end

      // R7 explicit corners
      run_word(8'h00, 8'h00, 1'b0, 1'b0);
      chk(m_res == 8'h00, "R7 zero maps to zero", m_res, 8'h00);
      run_word(8'h80, 8'h80, 1'b0, 1'b0);
      chk(m_res == 8'h80, "R7 most negative maps to itself", m_res, 8'h80);

      // R8 start while busy, R1 load while busy
      run_word(8'h0A, 8'hF6, 1'b1, 1'b0);
      run_word(8'h3C, 8'hC4, 1'b0, 1'b1);
      chk(m_res == 8'hC4, "R1 load while busy ignored", m_res, 8'hC4);

      // R12 load and start together
      @(negedge clk); load = 1'b1; start = 1'b1; lval = 8'h06;
      @(negedge clk); load = 1'b0; start = 1'b0;
      chk(m_busy, "R12 start taken with load", m_busy, 1'b1);
      repeat (8) @(negedge clk);
      chk(m_done && m_res == 8'hFA, "R12 new value negated", m_res, 8'hFA);
      @(negedge clk);

      // R9 reset during a word
      @(negedge clk); load = 1'b1; lval = 8'hFF;
      @(negedge clk); load = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk(m_res == 8'h00 && !m_busy && !m_done && !m_svld, "R9 reset mid-word",
          {m_res, m_busy, m_done, m_svld}, 11'h0);
      chk(!c_busy && c_res == 8'h00, "R9 reset incrementer form", c_res, 8'h00);

      // R6 fresh word after reset
      run_word(8'h01, 8'hFF, 1'b0, 1'b0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule